// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block moves a small processor core between four privilege levels, numbered 0 to 3. When the core raises an exception it pulses `take_i` with the exception class, the destination level, the preferred return address and the vector base of that level. In the same cycle the block stores the running status word and the return address in the save slots of the destination level. It then loads a fixed entry status word and branches the program counter into the vector table.

A pulse on `ret_i` undoes an entry. The block reads the save slots of the level it is running at. It loads the saved status word and the saved link address in one clock edge, so no half-updated state is ever visible. It first checks that the saved word names a level no higher than the current one. It also checks that the execution width the saved word asks for matches the width configured for that level. A return that fails either check keeps the current level, sets the illegal-state flag and still loads the program counter. The stack-pointer select output follows the status word. Saving general-purpose registers, decoding instructions and routing interrupts are left to other blocks.

Status word layout, bit positions used by the rest of the core:

| Bits | Meaning |
|------|---------|
| [1:0] | privilege level |
| [2] | stack select: 1 = the level's own pointer, 0 = level-0 pointer |
| [3] | execution width: 1 = 64-bit, 0 = 32-bit |
| [4] | illegal-state flag |
| [8:5] | masks {debug, async-abort, IRQ, FIQ} |

Top module: `excp_seq`

## Requirements
- R1: On a take, the status word held before the edge is written into the saved-status slot of `take_level`. Slots of other levels are unchanged. A later legal return from that level restores exactly that word.
- R2: On a take, `ret_addr` is written into the link slot of `take_level`. A later return from that level loads exactly that value into `pc_o`.
- R3: One cycle after a take, `stat_o` holds the following fixed entry word:
  - level = `take_level`;
  - stack select = 1;
  - width = the configured width of `take_level`;
  - illegal = 0;
  - debug, async-abort and IRQ masks set;
  - FIQ mask set only for class 2 (FIQ) or 3 (SError);
  - all bits above bit 8 zero.
- R4: One cycle after a take, `pc_o` = `vec_base` + 0x80 × `take_type`, where classes are encoded 0 synchronous, 1 IRQ, 2 FIQ, 3 SError.
- R5: On a legal return from level L, `stat_o` becomes saved-status[L] and `pc_o` becomes link[L] in the same cycle. With no request, `stat_o` and `pc_o` hold.
- R6: The configured width of level k is `width_cfg[k]` for k = 0..2, and the parameter `TOP_W64` for level 3. A return whose saved width bit differs from the configured width of its saved level is illegal.
- R7: A return whose saved level is above the current level is illegal. On any illegal return, bits [3:0] and [8:5] of `stat_o` are kept, bit 4 is set, and `pc_o` is still loaded from link[L]. A return never raises the level.
- R8: `sp_sel_o` equals the status level when stack select is 1, and 0 otherwise. After a take it names the destination level.
- R9: When `take_i` and `ret_i` are asserted together, only the take is performed.
- R10: After reset, `stat_o` = level 3, stack select 1, width `TOP_W64`, illegal 0, all four masks set (0x1EF with the default parameters). `pc_o` = `RST_PC`, and `sp_sel_o` = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| take_i | input | 1 | exception-take pulse |
| take_type | input | 2 | exception class (0 sync, 1 IRQ, 2 FIQ, 3 SError) |
| take_level | input | 2 | destination privilege level |
| ret_addr | input | AW | preferred return address to save |
| vec_base | input | AW | vector table base for the destination level |
| ret_i | input | 1 | exception-return pulse |
| width_cfg | input | 3 | 64-bit enable for levels 0..2, each owned by the level above |
| stat_o | output | SW | current status word |
| pc_o | output | AW | program counter |
| sp_sel_o | output | 2 | index of the active stack pointer |

## Verification
The hardest case to reach is a width-mismatch return. The saved word always copies a status that was legal when it was saved. So the only way to get a mismatch is to change the width configuration while a saved word is waiting in a slot. The stimulus enters level 2 while its width bit is 1, nests an entry into level 3, clears that bit and then returns. A level-raising return is produced the same way: the bench enters level 0 straight from level 3, which leaves a level-3 word in the level-0 slot. A long pseudo-random run then mixes takes, returns, simultaneous requests and width changes against a model built from the requirements.

// File: rtl/excp_seq.sv
module excp_seq #(
  parameter int       AW      = 32,
  parameter int       SW      = 16,
  parameter bit       TOP_W64 = 1'b1,
  parameter logic [AW-1:0] RST_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [1:0]    take_type,
  input  logic [1:0]    take_level,
  input  logic [AW-1:0] ret_addr,
  input  logic [AW-1:0] vec_base,
  input  logic          ret_i,
  input  logic [2:0]    width_cfg,
  output logic [SW-1:0] stat_o,
  output logic [AW-1:0] pc_o,
  output logic [1:0]    sp_sel_o
);
  localparam int NLVL      = 4;
  localparam int VEC_SHIFT = 7;
  localparam logic [SW-1:0] ILL_BIT  = SW'(16);
  localparam logic [SW-1:0] RST_STAT = SW'({4'b1111, 1'b0, TOP_W64, 1'b1, 2'b11});

  logic [SW-1:0] stat_q;
  logic [AW-1:0] pc_q;
  logic [SW-1:0] sav_stat [NLVL];
  logic [AW-1:0] sav_link [NLVL];
  logic [SW-1:0] entry_stat;

  wire [1:0]    cur_lvl = stat_q[1:0];
  wire [3:0]    lvl_w64 = {TOP_W64, width_cfg};
  wire [SW-1:0] ret_stat = sav_stat[cur_lvl];
  wire [1:0]    ret_lvl  = ret_stat[1:0];
  wire          ret_bad  = (ret_lvl > cur_lvl) || (ret_stat[3] != lvl_w64[ret_lvl]);
  wire [AW-1:0] vec_tgt  = vec_base + (AW'(take_type) << VEC_SHIFT);

  always_comb begin
    entry_stat      = '0;
    entry_stat[1:0] = take_level;
    entry_stat[2]   = 1'b1;
    entry_stat[3]   = lvl_w64[take_level];
    entry_stat[8:6] = 3'b111;
    entry_stat[5]   = take_type[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= RST_STAT;
      pc_q   <= RST_PC;
      for (int k = 0; k < NLVL; k++) begin
        sav_stat[k] <= '0;
        sav_link[k] <= '0;
      end
    end else if (take_i) begin
      sav_stat[take_level] <= stat_q;
      sav_link[take_level] <= ret_addr;
      stat_q <= entry_stat;
      pc_q   <= vec_tgt;
    end else if (ret_i) begin
      pc_q   <= sav_link[cur_lvl];
      stat_q <= ret_bad ? (stat_q | ILL_BIT) : ret_stat;
    end
  end

  assign stat_o   = stat_q;
  assign pc_o     = pc_q;
  assign sp_sel_o = stat_q[2] ? stat_q[1:0] : 2'd0;
endmodule

// File: rtl/excp_seq_chk.sv
module excp_seq_chk #(
  parameter int AW      = 32,
  parameter int SW      = 16,
  parameter bit TOP_W64 = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_i,
  input logic          ret_i,
  input logic [1:0]    take_type,
  input logic [1:0]    take_level,
  input logic [AW-1:0] vec_base,
  input logic [2:0]    width_cfg,
  input logic [SW-1:0] stat_o,
  input logic [AW-1:0] pc_o,
  input logic [1:0]    sp_sel_o
);
  logic [3:0] cfg_q;
  always_ff @(posedge clk) cfg_q <= {TOP_W64, width_cfg};

  assert_entry_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (stat_o[1:0] == $past(take_level)) && !stat_o[4]);

  assert_vector_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> pc_o == $past(vec_base) + (AW'($past(take_type)) << 7));

  assert_entry_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> sp_sel_o == $past(take_level));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !ret_i) |=> $stable(stat_o) && $stable(pc_o));

  assert_width_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i) |=> stat_o[4] || (stat_o[3] == cfg_q[stat_o[1:0]]));

  assert_no_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i) |=> stat_o[1:0] <= $past(stat_o[1:0]));

  assert_take_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && ret_i) |=> stat_o[2] && (stat_o[1:0] == $past(take_level)));
endmodule

bind excp_seq excp_seq_chk #(.AW(AW), .SW(SW), .TOP_W64(TOP_W64)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_i(take_i), .ret_i(ret_i),
  .take_type(take_type), .take_level(take_level), .vec_base(vec_base),
  .width_cfg(width_cfg), .stat_o(stat_o), .pc_o(pc_o), .sp_sel_o(sp_sel_o)
);

// File: tb/test_excp_seq.sv
module test_excp_seq;
  localparam int AW = 32;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          take_i = 1'b0, ret_i = 1'b0;
  logic [1:0]    take_type = '0, take_level = '0;
  logic [AW-1:0] ret_addr = '0, vec_base = '0;
  logic [2:0]    width_cfg = '0;
  logic [SW-1:0] stat_o;
  logic [AW-1:0] pc_o;
  logic [1:0]    sp_sel_o;

  excp_seq #(.AW(AW), .SW(SW), .TOP_W64(1'b1), .RST_PC('0)) i_excp_seq (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .take_type(take_type),
    .take_level(take_level), .ret_addr(ret_addr), .vec_base(vec_base),
    .ret_i(ret_i), .width_cfg(width_cfg), .stat_o(stat_o), .pc_o(pc_o),
    .sp_sel_o(sp_sel_o)
  );

  always #2 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [SW-1:0] m_stat;
  logic [AW-1:0] m_pc;
  logic [SW-1:0] m_sav [4];
  logic [AW-1:0] m_link [4];
  logic [31:0]   rng = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic check(input string tag);
    logic [1:0] esp = m_stat[2] ? m_stat[1:0] : 2'd0;
    nvec++;
    if (stat_o !== m_stat || pc_o !== m_pc || sp_sel_o !== esp) begin
      nbad++;
      if (stat_o !== m_stat) $display("FAIL %s stat: got %h expected %h", tag, stat_o, m_stat);
      if (pc_o !== m_pc)     $display("FAIL %s pc: got %h expected %h", tag, pc_o, m_pc);
      if (sp_sel_o !== esp)  $display("FAIL R8 (%s) sp_sel: got %0d expected %0d", tag, sp_sel_o, esp);
    end
  endtask

  // one request cycle; model follows the requirements, check after the edge
  task automatic step(input logic tk, input logic rt, input logic [1:0] ty,
                      input logic [1:0] lv, input logic [AW-1:0] ra,
                      input logic [AW-1:0] vb, input logic [2:0] wc);
    string tag;
    @(negedge clk);
    take_i = tk; ret_i = rt; take_type = ty; take_level = lv;
    ret_addr = ra; vec_base = vb; width_cfg = wc;
    if (tk) begin
      logic [3:0] w64 = {1'b1, wc};
      tag = rt ? "R9" : "R1,R2,R3,R4";
      m_sav[lv] = m_stat;
      m_link[lv] = ra;
      m_stat = '0;
      m_stat[1:0] = lv; m_stat[2] = 1'b1; m_stat[3] = w64[lv];
      m_stat[8:6] = 3'b111; m_stat[5] = ty[1];
      m_pc = vb + (AW'(ty) << 7);
    end else if (rt) begin
      logic [1:0] cl = m_stat[1:0];
      logic [SW-1:0] s = m_sav[cl];
      logic [3:0] w64 = {1'b1, wc};
      logic hi = s[1:0] > cl;
      logic wm = s[3] != w64[s[1:0]];
      m_pc = m_link[cl];
      if (hi || wm) begin
        tag = hi ? "R7" : "R6";
        m_stat = m_stat | SW'(16);
      end else begin
        tag = "R1,R2,R5";
        m_stat = s;
      end
    end else tag = "R5 idle";
    @(negedge clk);
    take_i = 1'b0; ret_i = 1'b0;
    check(tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    m_stat = SW'(16'h01EF);
    m_pc = '0;
    for (int k = 0; k < 4; k++) begin m_sav[k] = '0; m_link[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R10 reset");

    // sweep every width setting, class and destination level
    for (int w = 0; w < 8; w++)
      for (int t = 0; t < 4; t++)
        for (int l = 0; l < 4; l++) begin
          step(1'b1, 1'b0, 2'(t), 2'(l), 32'h4000_0000 + 32'(w*64 + t*4 + l) * 4,
               32'h0001_0000 * 32'(l + 1), 3'(w));
          step(1'b0, 1'b1, 2'd0, 2'd0, '0, '0, 3'(w));
        end

    // R7: level-3 word left in level-0 slot, then returned from level 0
    step(1'b1, 1'b0, 2'd0, 2'd3, 32'h0000_3000, 32'h0003_0000, 3'b111);
    step(1'b1, 1'b0, 2'd1, 2'd0, 32'h0000_0100, 32'h0000_8000, 3'b111);
    step(1'b0, 1'b1, 2'd0, 2'd0, '0, '0, 3'b111);
    step(1'b0, 1'b0, 2'd0, 2'd0, '0, '0, 3'b111);

    // R6: width bit of level 2 cleared while its saved word waits
    step(1'b1, 1'b0, 2'd0, 2'd3, 32'h0000_0200, 32'h0003_0000, 3'b100);
    step(1'b1, 1'b0, 2'd2, 2'd2, 32'h0000_0204, 32'h0002_0000, 3'b100);
    step(1'b1, 1'b0, 2'd3, 2'd3, 32'h0000_0208, 32'h0003_0000, 3'b100);
    step(1'b0, 1'b1, 2'd0, 2'd0, '0, '0, 3'b000);

    // R9: simultaneous requests
    step(1'b1, 1'b1, 2'd1, 2'd1, 32'h0000_0300, 32'h0001_0000, 3'b010);
    step(1'b0, 1'b1, 2'd0, 2'd0, '0, '0, 3'b010);

    // pseudo-random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] op;
      rng = nxt(rng);
      op = rng[2:0];
      step(op < 3'd3 || op == 3'd7, op inside {3'd3, 3'd4, 3'd5, 3'd7},
           rng[4:3], rng[6:5], {rng[31:8], 8'h00}, {rng[23:12], 20'h0},
           (op == 3'd6) ? rng[11:9] : width_cfg);
    end

    // reset mid-run returns to R10 state
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    m_stat = SW'(16'h01EF); m_pc = '0;
    for (int k = 0; k < 4; k++) begin m_sav[k] = '0; m_link[k] = '0; end
    check("R10 re-reset");

    done = 1'b1;
    summary();
  end
endmodule